// File: doc/BRIEF.md
# Dual-Channel Wiper Step Controller

This block holds the tap-position codes for two digitally adjustable resistor channels and changes them in response to single-cycle commands. Each command carries an operation, a channel select and a flag that applies it to every channel at once. The operations are a direct load, a one-step linear move up or down, and a logarithmic-style step of about +6 dB or -6 dB. The logarithmic step doubles or halves the code.

The codes are register outputs that drive a resistor ladder's tap decoder, and they are always visible for readback. The code width is a parameter: 6 bits gives 64 taps and 8 bits gives 256 taps. After reset every channel sits at midscale. Every step saturates at the ends of the range, so a code never wraps.

Top module: `wiper_step_ctrl`

## Requirements
- R1: On a synchronous reset every channel code becomes midscale, 2^(CODE_W-1): 128 for 8 bits, 32 for 6 bits.
- R2: Operation code 1 (load) stores cmd_data into each addressed channel.
- R3: Operation code 2 raises an addressed code by exactly one. Operation code 3 lowers it by exactly one.
- R4: Operation code 2 at full scale (all ones) leaves the code at full scale. Operation code 3 at zero leaves it at zero.
- R5: Operation code 5 (-6 dB) replaces the code with the code shifted right by one bit, with a zero shifted in at the MSB.
- R6: Operation code 4 (+6 dB) shifts the code left by one bit. If the MSB is set, the result is full scale. Zero stays zero.
- R7: When cmd_all is 1, both channels apply the operation on the same edge and cmd_sel is ignored.
- R8: When cmd_all is 0, cmd_sel value 0 addresses channel 0 (wiper_codes[CODE_W-1:0]) and value 1 addresses channel 1 (the upper CODE_W bits). Any other cmd_sel value, or cmd_valid low, leaves every code unchanged.
- R9: Operation codes 0, 6 and 7 leave every code unchanged.
- R10: A command sampled with cmd_valid high at a rising edge shows on wiper_codes immediately after that edge. A new command may be given in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Operation code |
| cmd_sel | input | SEL_W (2) | Channel select |
| cmd_all | input | 1 | Apply to all channels |
| cmd_data | input | CODE_W (8) | Load value for operation 1 |
| wiper_codes | output | NUM_CH*CODE_W (16) | Channel codes, channel 0 in the low bits |

## Verification
The bench builds two copies of the block: one at the default 8-bit width and one at 6 bits. Both receive the same command stream, with the load data truncated for the 6-bit copy. The 6-bit copy reaches the saturation corners at different data values, so one stimulus exercises the full-scale and MSB-set doubling cases at both widths. A select width of 2 bits over two channels leaves the select values 2 and 3 unmapped, which makes the ignored-select rule observable.

// File: rtl/wsc_pkg.sv
package wsc_pkg;
  localparam int OP_W = 3;
  typedef enum logic [OP_W-1:0] {
    OP_NOP    = 3'd0,
    OP_LOAD   = 3'd1,
    OP_UP     = 3'd2,
    OP_DOWN   = 3'd3,
    OP_DOUBLE = 3'd4,
    OP_HALVE  = 3'd5
  } wsc_op_e;
endpackage

// File: rtl/wsc_sel_decode.sv
module wsc_sel_decode #(
  parameter int NUM_CH = 2,
  parameter int SEL_W  = 2
) (
  input  logic              valid,
  input  logic              all,
  input  logic [SEL_W-1:0]  sel,
  output logic [NUM_CH-1:0] en
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_en
    assign en[i] = valid && (all || (sel == SEL_W'(i)));
  end
endmodule

// File: rtl/wsc_step_alu.sv
module wsc_step_alu
  import wsc_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic [OP_W-1:0]   op,
  input  logic [CODE_W-1:0] cur,
  input  logic [CODE_W-1:0] data,
  output logic [CODE_W-1:0] nxt
);
  localparam logic [CODE_W-1:0] FULL = {CODE_W{1'b1}};

  always_comb begin
    nxt = cur;
    case (op)
      OP_LOAD:   nxt = data;
      OP_UP:     nxt = (cur == FULL) ? FULL : cur + 1'b1;
      OP_DOWN:   nxt = (cur == '0) ? '0 : cur - 1'b1;
      OP_DOUBLE: nxt = cur[CODE_W-1] ? FULL : {cur[CODE_W-2:0], 1'b0};
      OP_HALVE:  nxt = {1'b0, cur[CODE_W-1:1]};
      default:   nxt = cur;
    endcase
  end
endmodule

// File: rtl/wsc_wiper_reg.sv
module wsc_wiper_reg
  import wsc_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [OP_W-1:0]   op,
  input  logic [CODE_W-1:0] data,
  input  logic [CODE_W-1:0] nxt,
  output logic [CODE_W-1:0] code
);
  localparam logic [CODE_W-1:0] FULL = {CODE_W{1'b1}};
  localparam logic [CODE_W-1:0] MID  = CODE_W'(1) << (CODE_W - 1);

  always_ff @(posedge clk) begin
    if (rst)     code <= MID;
    else if (en) code <= nxt;
  end

  AST_RESET_MID: assert property (@(posedge clk) rst |=> code == MID); // R1
  AST_LOAD_DATA: assert property (@(posedge clk) disable iff (rst)
    (en && op == OP_LOAD) |=> code == $past(data)); // R2
  AST_UP_ONE: assert property (@(posedge clk) disable iff (rst)
    (en && op == OP_UP && code != FULL) |=> code == $past(code) + 1'b1); // R3
  AST_UP_SAT: assert property (@(posedge clk) disable iff (rst)
    (en && op == OP_UP && code == FULL) |=> code == FULL); // R4
  AST_DOWN_FLOOR: assert property (@(posedge clk) disable iff (rst)
    (en && op == OP_DOWN && code == '0) |=> code == '0); // R4
  AST_HALVE_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (en && op == OP_HALVE) |=> code == ($past(code) >> 1)); // R5
  AST_DOUBLE_SAT: assert property (@(posedge clk) disable iff (rst)
    (en && op == OP_DOUBLE && code[CODE_W-1]) |=> code == FULL); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(code)); // R8
  AST_BAD_OP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (en && op > OP_HALVE) |=> $stable(code)); // R9
endmodule

// File: rtl/wiper_step_ctrl.sv
module wiper_step_ctrl
  import wsc_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int NUM_CH = 2,
  parameter int SEL_W  = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cmd_valid,
  input  logic [2:0]               cmd_op,
  input  logic [SEL_W-1:0]         cmd_sel,
  input  logic                     cmd_all,
  input  logic [CODE_W-1:0]        cmd_data,
  output logic [NUM_CH*CODE_W-1:0] wiper_codes
);
  localparam int TOT_W = NUM_CH * CODE_W;

  logic [NUM_CH-1:0] ch_en;

  wsc_sel_decode #(.NUM_CH(NUM_CH), .SEL_W(SEL_W)) u_dec (
    .valid(cmd_valid), .all(cmd_all), .sel(cmd_sel), .en(ch_en)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [CODE_W-1:0] cur;
    logic [CODE_W-1:0] nxt;

    wsc_step_alu #(.CODE_W(CODE_W)) u_alu (
      .op(cmd_op), .cur(cur), .data(cmd_data), .nxt(nxt)
    );

    wsc_wiper_reg #(.CODE_W(CODE_W)) u_reg (
      .clk(clk), .rst(rst), .en(ch_en[c]), .op(cmd_op),
      .data(cmd_data), .nxt(nxt), .code(cur)
    );

    assign wiper_codes[c*CODE_W +: CODE_W] = cur;
  end

  AST_UNMAPPED_SEL: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_all && cmd_sel >= SEL_W'(NUM_CH)) |=> $stable(wiper_codes)); // R8
  AST_NO_CMD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> $stable(wiper_codes)); // R8
  AST_ALL_LOCKSTEP: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_all && cmd_op == OP_LOAD) |=>
      wiper_codes == {NUM_CH{$past(cmd_data)}}); // R7
  AST_CMD_VISIBLE: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_all && cmd_op == OP_LOAD && $past(wiper_codes) != TOT_W'(0)
     && cmd_data != wiper_codes[CODE_W-1:0]) |=> !$stable(wiper_codes)); // R10
endmodule

// File: tb/wiper_step_ctrl_bench.sv
`timescale 1ns/1ps
module wiper_step_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [1:0] cmd_sel = 2'd0;
  logic       cmd_all = 1'b0;
  logic [7:0] cmd_data = 8'd0;
  logic [15:0] codes8;
  logic [11:0] codes6;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string cur_req = "R1";
  int m8 [2];
  int m6 [2];

  always #4 clk = ~clk;

  wiper_step_ctrl #(.CODE_W(8)) u_wiper_step_ctrl (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_sel(cmd_sel), .cmd_all(cmd_all), .cmd_data(cmd_data),
    .wiper_codes(codes8)
  );

  wiper_step_ctrl #(.CODE_W(6)) u_wiper_step_ctrl_w6 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_sel(cmd_sel), .cmd_all(cmd_all), .cmd_data(cmd_data[5:0]),
    .wiper_codes(codes6)
  );

  function automatic int step(int w, int op, int cur, int d);
    int mx = (1 << w) - 1;
    case (op)
      1: return d & mx;
      2: return (cur == mx) ? mx : cur + 1;
      3: return (cur == 0) ? 0 : cur - 1;
      4: return (cur * 2 > mx) ? mx : cur * 2;
      5: return cur / 2;
      default: return cur;
    endcase
  endfunction

  always @(posedge clk) begin
    for (int ch = 0; ch < 2; ch++) begin
      if (rst) begin
        m8[ch] <= 128;
        m6[ch] <= 32;
      end else if (cmd_valid && (cmd_all || cmd_sel == ch)) begin
        m8[ch] <= step(8, cmd_op, m8[ch], cmd_data);
        m6[ch] <= step(6, cmd_op, m6[ch], cmd_data);
      end
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      for (int ch = 0; ch < 2; ch++) begin
        chk(cur_req, $sformatf("w8 ch%0d", ch), int'(codes8[ch*8 +: 8]), m8[ch]);
        chk(cur_req, $sformatf("w6 ch%0d", ch), int'(codes6[ch*6 +: 6]), m6[ch]);
      end
    end
  end

  task automatic cmd(int op, int sel, bit all, int data);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op = 3'(op);
    cmd_sel = 2'(sel);
    cmd_all = all;
    cmd_data = 8'(data);
  endtask

  task automatic idle();
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R1: midscale straight after reset
    chk("R1", "w8 ch0", int'(codes8[7:0]), 128);
    chk("R1", "w8 ch1", int'(codes8[15:8]), 128);
    chk("R1", "w6 ch0", int'(codes6[5:0]), 32);
    chk("R1", "w6 ch1", int'(codes6[11:6]), 32);

    cur_req = "R3";
    cmd(2, 0, 0, 0); cmd(2, 0, 0, 0); cmd(2, 0, 0, 0);
    cmd(3, 1, 0, 0); cmd(3, 1, 0, 0); idle();

    cur_req = "R2";
    cmd(1, 0, 0, 8'hFE); cmd(1, 1, 0, 0); idle();

    cur_req = "R4";
    cmd(2, 0, 0, 0); cmd(2, 0, 0, 0); cmd(2, 0, 0, 0);
    cmd(3, 1, 0, 0); cmd(1, 1, 0, 1); cmd(3, 1, 0, 0); cmd(3, 1, 0, 0); idle();

    cur_req = "R5";
    cmd(1, 0, 0, 8'hB5); cmd(5, 0, 0, 0); cmd(5, 0, 0, 0); cmd(5, 0, 0, 0); idle();

    cur_req = "R6";
    cmd(1, 0, 0, 8'h41); cmd(4, 0, 0, 0); cmd(4, 0, 0, 0);
    cmd(1, 1, 0, 8'h60); cmd(4, 1, 0, 0);
    cmd(1, 0, 0, 0); cmd(4, 0, 0, 0); idle();

    cur_req = "R7";
    cmd(1, 0, 1, 8'h33); cmd(2, 2, 1, 0); cmd(4, 3, 1, 0); cmd(5, 1, 1, 0); idle();

    cur_req = "R8";
    cmd(1, 2, 0, 8'h07); cmd(2, 3, 0, 0); cmd(5, 3, 0, 0);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd1; cmd_all = 1'b1; cmd_data = 8'h00;
    idle();

    cur_req = "R9";
    cmd(6, 0, 1, 8'h11); cmd(7, 1, 1, 8'h22); cmd(0, 0, 1, 8'h33); idle();

    cur_req = "R10";
    for (int i = 0; i < 400; i++)
      cmd((i * 7) % 8, i % 4, (i % 5) == 0, i * 37);
    idle();
    idle();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule